// File: doc/BRIEF.md
# Four-Channel TDM Slot Serializer and Deserializer

This block connects four transmit and four receive 8-bit sample channels to a time-division multiplexed serial bus. The bus has a bit clock, a frame pulse, one serial output and one serial input. A frame pulse that is sampled high on a rising bit-clock edge marks bit 0 of slot 0. Every later bit position is counted from that edge, with eight bits to each slot. Each channel has its own 7-bit slot number and its own enable, so the channel's byte can be placed anywhere in a frame of 8 to 128 slots. The frame length is set only by the spacing of the frame pulses.

On the transmit side, the byte of the channel that owns a slot is loaded into a shift register on the first edge of that slot. It then leaves on rising edges, most significant bit first. A separate output-enable tells the pad when to drive, and it is low in slots that no channel owns. On the receive side, the input is sampled on falling edges into a shared shift register. When the eighth bit of a slot arrives, the byte is handed to every enabled receive channel that is mapped to that slot, together with a one-period strobe.

A two-state frame tracker governs the bus position. ST_HUNT is the state after reset: nothing is driven or received, and the tracker waits. The transition HUNT_TO_LOCKED happens on the first sampled frame pulse. In ST_LOCKED, the transition LOCKED_RESTART happens when a frame pulse arrives at any position and returns the count to zero. The transition LOCKED_TO_HUNT happens when 1024 bit positions (128 slots) pass without a frame pulse. A frame pulse on that last position takes precedence and keeps the tracker locked.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, and until the first frame pulse, dx_oe and dx are 0, every rx_valid bit is 0 and every rx_data byte is 0.
- R2: A rising edge at which fsync is high becomes position 0 (slot 0, bit 0). Each following rising edge advances the position by one. Position p is slot p/8, bit p%8. A frame pulse at any position restarts the count.
- R3: During the bit period that begins at the rising edge of position 8s+k, dx carries bit 7-k of the owning channel's tx_data byte, so the most significant bit is first. The byte is taken at the first edge of slot s. Channel c's byte is tx_data[8c+7:8c].
- R4: dx_oe is high for all eight bit periods of a slot owned by an enabled transmit channel. It is low in every other slot, and dx is 0 whenever dx_oe is low.
- R5: When more than one enabled transmit channel holds the current slot number, the channel with the lowest index supplies the byte.
- R6: dr is sampled on falling edges, most significant bit first. After the falling edge of bit 7 of slot s, rx_data[8c+7:8c] holds the received byte and rx_valid[c] is high for one bit-clock period, for each enabled channel c whose rx_slot equals s. At all other times rx_valid is 0.
- R7: A channel whose tx_en bit is 0 never owns a slot. A channel whose rx_en bit is 0 gets no strobe, and its rx_data byte keeps its previous value.
- R8: Slot numbers 0 to 127 are all usable, including 0 and 127. Channel c's slot field is bits [7c+6:7c] of tx_slot and rx_slot.
- R9: If 1024 bit positions pass without a frame pulse, the block returns to the hunting state. dx_oe and rx_valid then stay 0 until the next frame pulse.
- R10: Two enabled receive channels mapped to the same slot both receive that slot's byte and strobe together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; transmit on rising edge, receive on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame pulse, sampled on rising edges |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for the transmit pad |
| dr | input | 1 | Serial receive data |
| tx_en | input | 4 | Per-channel transmit enable |
| tx_slot | input | 28 | Per-channel transmit slot numbers, 7 bits each |
| tx_data | input | 32 | Per-channel transmit bytes, 8 bits each |
| rx_en | input | 4 | Per-channel receive enable |
| rx_slot | input | 28 | Per-channel receive slot numbers, 7 bits each |
| rx_data | output | 32 | Per-channel received bytes |
| rx_valid | output | 4 | Per-channel one-period receive strobe |

## Verification
Frame restart and frame-loss detection can fall on the same rising edge. After a full 128-slot frame, the next frame pulse arrives on exactly the edge where the position counter would wrap, and the bench expects the block to stay locked and drive slot 0 at once. In a contrast run, the frame pulse is withheld on that edge, and the bench expects dx_oe and rx_valid to stay low even though a channel is enabled on slot 0. A receive strobe and a slot-ownership change also share each slot boundary. The sweeps judge both at every bit position against the arithmetic model of the bench.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } frame_state_e;
endpackage

// File: rtl/pcm_slot_timer.sv
`timescale 1ns/1ps
module pcm_slot_timer
    import pcm_tdm_pkg::*;
#(
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + BIT_IDX_W
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_nxt,
    output logic             locked,
    output logic             locked_nxt
);
    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    frame_state_e state_q, state_d;
    logic [POS_W-1:0] pos_q;

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_nxt;
        end
    end

    // next state and position
    always_comb begin
        state_d = state_q;
        pos_nxt = pos_q;
        unique case (state_q)
            ST_HUNT: begin
                pos_nxt = '0;
                if (fsync) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (fsync) begin
                    pos_nxt = '0;
                end else if (pos_q == POS_LAST) begin
                    state_d = ST_HUNT;
                    pos_nxt = '0;
                end else begin
                    pos_nxt = pos_q + 1'b1;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        pos        = pos_q;
        locked     = (state_q == ST_LOCKED);
        locked_nxt = (state_d == ST_LOCKED);
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
`timescale 1ns/1ps
module pcm_tx_serializer
    import pcm_tdm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + BIT_IDX_W
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     locked_nxt,
    input  logic [POS_W-1:0]         pos_nxt,
    input  logic [NUM_CH-1:0]        tx_en,
    input  logic [NUM_CH*SLOT_W-1:0] tx_slot,
    input  logic [NUM_CH*BYTE_W-1:0] tx_data,
    output logic                     dx,
    output logic                     dx_oe
);
    logic [SLOT_W-1:0]    slot_nxt;
    logic [BIT_IDX_W-1:0] bit_nxt;
    logic [NUM_CH-1:0]    owns;
    logic [BYTE_W-1:0]    owner_byte;
    logic [BYTE_W-1:0]    shift_q;
    logic                 oe_q;

    assign slot_nxt = pos_nxt[POS_W-1:BIT_IDX_W];
    assign bit_nxt  = pos_nxt[BIT_IDX_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_own
        assign owns[c] = tx_en[c] && (tx_slot[c*SLOT_W +: SLOT_W] == slot_nxt);
    end

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        owner_byte = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (owns[c]) owner_byte = tx_data[c*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            oe_q    <= 1'b0;
        end else if (!locked_nxt) begin
            shift_q <= '0;
            oe_q    <= 1'b0;
        end else if (bit_nxt == '0) begin
            shift_q <= owner_byte;
            oe_q    <= |owns;
        end else begin
            shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign dx    = oe_q & shift_q[BYTE_W-1];
    assign dx_oe = oe_q;
endmodule

// File: rtl/pcm_rx_deserializer.sv
`timescale 1ns/1ps
module pcm_rx_deserializer
    import pcm_tdm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + BIT_IDX_W
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     locked,
    input  logic [POS_W-1:0]         pos,
    input  logic                     dr,
    input  logic [NUM_CH-1:0]        rx_en,
    input  logic [NUM_CH*SLOT_W-1:0] rx_slot,
    output logic [NUM_CH*BYTE_W-1:0] rx_data,
    output logic [NUM_CH-1:0]        rx_valid
);
    localparam logic [BIT_IDX_W-1:0] BIT_LAST = {BIT_IDX_W{1'b1}};

    logic [SLOT_W-1:0]    slot_now;
    logic                 last_bit;
    logic [BYTE_W-1:0]    shift_q;
    logic [BYTE_W-1:0]    full_byte;
    logic [NUM_CH-1:0]    take;

    assign slot_now  = pos[POS_W-1:BIT_IDX_W];
    assign last_bit  = locked && (pos[BIT_IDX_W-1:0] == BIT_LAST);
    assign full_byte = {shift_q[BYTE_W-2:0], dr};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_take
        assign take[c] = last_bit && rx_en[c] &&
                         (rx_slot[c*SLOT_W +: SLOT_W] == slot_now);
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            rx_data  <= '0;
            rx_valid <= '0;
        end else begin
            if (locked) shift_q <= full_byte;
            rx_valid <= take;
            for (int c = 0; c < NUM_CH; c++) begin
                if (take[c]) rx_data[c*BYTE_W +: BYTE_W] <= full_byte;
            end
        end
    end
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port
    import pcm_tdm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + BIT_IDX_W
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     fsync,
    output logic                     dx,
    output logic                     dx_oe,
    input  logic                     dr,
    input  logic [NUM_CH-1:0]        tx_en,
    input  logic [NUM_CH*SLOT_W-1:0] tx_slot,
    input  logic [NUM_CH*BYTE_W-1:0] tx_data,
    input  logic [NUM_CH-1:0]        rx_en,
    input  logic [NUM_CH*SLOT_W-1:0] rx_slot,
    output logic [NUM_CH*BYTE_W-1:0] rx_data,
    output logic [NUM_CH-1:0]        rx_valid
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_nxt;
    logic             locked;
    logic             locked_nxt;

    pcm_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .pos        (pos),
        .pos_nxt    (pos_nxt),
        .locked     (locked),
        .locked_nxt (locked_nxt)
    );

    pcm_tx_serializer #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_tx (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .locked_nxt (locked_nxt),
        .pos_nxt    (pos_nxt),
        .tx_en      (tx_en),
        .tx_slot    (tx_slot),
        .tx_data    (tx_data),
        .dx         (dx),
        .dx_oe      (dx_oe)
    );

    pcm_rx_deserializer #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_rx (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .locked   (locked),
        .pos      (pos),
        .dr       (dr),
        .rx_en    (rx_en),
        .rx_slot  (rx_slot),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk #(
    parameter int NUM_CH = 4,
    parameter int POS_W  = 10
) (
    input logic              bclk,
    input logic              rst_n,
    input logic              fsync,
    input logic              dx_oe,
    input logic [NUM_CH-1:0] rx_valid,
    input logic              locked,
    input logic [POS_W-1:0]  pos
);
    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    AST_FSYNC_RESTART: assert property (@(posedge bclk) disable iff (!rst_n)
        fsync |=> (locked && pos == '0)) else $error("frame pulse did not restart count"); // R2

    AST_POS_STEP: assert property (@(posedge bclk) disable iff (!rst_n)
        (locked && !fsync && pos != POS_LAST) |=> (locked && pos == $past(pos) + 1'b1)) else $error("position did not advance"); // R2

    AST_OE_HOLD_SLOT: assert property (@(posedge bclk) disable iff (!rst_n)
        (dx_oe && pos[2:0] != 3'd7 && !fsync) |=> dx_oe) else $error("drive dropped inside slot"); // R4

    AST_HUNT_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
        !locked |-> (!dx_oe && rx_valid == '0)) else $error("activity while hunting"); // R9

    AST_RX_ON_LAST_BIT: assert property (@(posedge bclk) disable iff (!rst_n)
        (|rx_valid) |-> (locked && pos[2:0] == 3'd7)) else $error("strobe off the last bit"); // R6

    AST_RX_PULSE: assert property (@(posedge bclk) disable iff (!rst_n)
        (|rx_valid) |=> (rx_valid == '0)) else $error("strobe longer than one period"); // R6

    AST_LOST_FRAME: assert property (@(posedge bclk) disable iff (!rst_n)
        (locked && !fsync && pos == POS_LAST) |=> !locked) else $error("no return to hunt"); // R9
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.NUM_CH(NUM_CH), .POS_W(POS_W)) u_chk (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .dx_oe    (dx_oe),
    .rx_valid (rx_valid),
    .locked   (locked),
    .pos      (pos)
);

// File: tb/pcm_tdm_port_bench.sv
`timescale 1ns/1ps
module pcm_tdm_port_bench;
    localparam int NCH = 4;
    localparam int SW  = 7;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic dr = 1'b0;
    logic [NCH-1:0]    tx_en, rx_en;
    logic [NCH*SW-1:0] tx_slot, rx_slot;
    logic [NCH*8-1:0]  tx_data;
    wire               dx, dx_oe;
    wire  [NCH*8-1:0]  rx_data;
    wire  [NCH-1:0]    rx_valid;

    logic [SW-1:0] tsl [NCH];
    logic [SW-1:0] rsl [NCH];
    logic [7:0]    tdat [NCH];
    logic [7:0]    exp_rx [NCH];
    int n_tests = 0;
    int n_fail = 0;
    int seed = 0;
    bit done = 0;
    string tag = "";

    always #5 bclk = ~bclk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            tx_slot[c*SW +: SW] = tsl[c];
            rx_slot[c*SW +: SW] = rsl[c];
            tx_data[c*8 +: 8]   = tdat[c];
        end
    end

    pcm_tdm_port u_pcm_tdm_port (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .dx(dx), .dx_oe(dx_oe), .dr(dr),
        .tx_en(tx_en), .tx_slot(tx_slot), .tx_data(tx_data),
        .rx_en(rx_en), .rx_slot(rx_slot), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    function automatic logic [7:0] pat(int s);
        return 8'(s * 37 + seed * 11 + 5);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive nbits positions; a frame pulse precedes position 0 when start is set
    task automatic run_bits(int nbits, bit start);
        for (int t = 0; t < nbits; t++) begin
            int s = t / 8;
            int k = t % 8;
            int own = -1;
            int nown = 0;
            logic [7:0] b = pat(s);
            fsync = start && (t == 0);
            @(posedge bclk);
            #1 fsync = 1'b0;
            dr = b[7-k];
            #2;
            for (int c = 0; c < NCH; c++) begin
                if (tx_en[c] && tsl[c] == s[SW-1:0]) begin
                    nown++;
                    if (own < 0) own = c;
                end
            end
            check(tag != "" ? tag : (tx_en == '0 ? "R7" : "R4"), "dx_oe", dx_oe, own >= 0);
            if (own >= 0)
                check(tag != "" ? tag : (nown > 1 ? "R5" : "R3"), "dx", dx, tdat[own][7-k]);
            else
                check("R4", "dx idle", dx, 0);
            @(negedge bclk);
            #3;
            for (int c = 0; c < NCH; c++) begin
                bit ev = (k == 7) && rx_en[c] && (rsl[c] == s[SW-1:0]);
                int share = 0;
                for (int d = 0; d < NCH; d++)
                    if (rx_en[d] && rsl[d] == rsl[c]) share++;
                if (ev) exp_rx[c] = b;
                check(tag != "" ? tag : (!rx_en[c] ? "R7" : (share > 1 ? "R10" : "R6")),
                      "rx_valid", rx_valid[c], ev);
                check(tag != "" ? tag : (!rx_en[c] ? "R7" : "R6"),
                      "rx_data", rx_data[c*8 +: 8], exp_rx[c]);
            end
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            tsl[c] = '0; rsl[c] = '0; tdat[c] = 8'hA5; exp_rx[c] = '0;
        end
        tx_en = '1;
        rx_en = '1;
        #12;
        check("R1", "dx_oe in reset", dx_oe, 0);
        check("R1", "rx_valid in reset", rx_valid, 0);
        #11 rst_n = 1'b1;
        // R1: hunting, no frame pulse yet
        for (int i = 0; i < 12; i++) begin
            @(posedge bclk); #3;
            check("R1", "dx_oe hunting", dx_oe, 0);
            check("R1", "dx hunting", dx, 0);
            @(negedge bclk); #3;
            check("R1", "rx_valid hunting", rx_valid, 0);
            check("R1", "rx_data hunting", rx_data, 0);
        end
        @(posedge bclk); #3;

        // R7: everything disabled
        tx_en = '0; rx_en = '0;
        for (int c = 0; c < NCH; c++) begin tsl[c] = 7'(c); rsl[c] = 7'(c + 1); end
        run_bits(128, 1);

        // R3 R4 R6 R7: sweep of slot maps, enables and data
        for (int sh = 0; sh < 16; sh++) begin
            seed = sh;
            tx_en = (sh % 2 == 0) ? 4'hF : 4'(sh);
            rx_en = (sh % 2 == 0) ? 4'hF : ~4'(sh);
            for (int c = 0; c < NCH; c++) begin
                tsl[c]  = 7'((sh + c * 5) % 16);
                rsl[c]  = 7'((sh * 3 + c * 4 + 1) % 16);
                tdat[c] = 8'(sh * 29 + c * 71 + 3);
            end
            run_bits(128, 1);
        end

        // R5 R10: colliding slots
        seed = 20;
        tx_en = '1; rx_en = '1;
        tsl[0] = 7'd9; tsl[1] = 7'd5; tsl[2] = 7'd5; tsl[3] = 7'd5;
        rsl[0] = 7'd2; rsl[1] = 7'd2; rsl[2] = 7'd7; rsl[3] = 7'd7;
        tdat[0] = 8'h3C; tdat[1] = 8'h81; tdat[2] = 8'h7E; tdat[3] = 8'hFF;
        run_bits(128, 1);

        // R8: full 128-slot frame with slots 0 and 127
        seed = 31;
        tag = "R8";
        tsl[0] = 7'd127; tsl[1] = 7'd64; tsl[2] = 7'd0; tsl[3] = 7'd100;
        rsl[0] = 7'd127; rsl[1] = 7'd0;  rsl[2] = 7'd90; rsl[3] = 7'd33;
        run_bits(1024, 1);
        // frame pulse on the wrap edge keeps lock
        tag = "";
        run_bits(128, 1);

        // R2: early restart in the middle of slot 2
        tag = "R2";
        run_bits(20, 1);
        run_bits(128, 1);

        // R9: lost frame
        tag = "R9";
        run_bits(1024, 1);
        for (int i = 0; i < 16; i++) begin
            @(posedge bclk); #3;
            check("R9", "dx_oe after loss", dx_oe, 0);
            @(negedge bclk); #3;
            check("R9", "rx_valid after loss", rx_valid, 0);
        end
        @(posedge bclk); #3;
        tag = "";
        run_bits(128, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule